// File: doc/BRIEF.md
# Oversampled Phase-Frequency Detector with Lock Offset Pulse

This block compares a reference clock with a divided feedback clock and drives the two control lines of a charge pump: `up` asks the oscillator to speed up, and `dn` asks it to slow down. Both inputs are treated as asynchronous. Each one is sampled by a fast system clock through a synchronizer chain, and a rising-edge detector follows the chain. Two state flops form a three-state detector. A reference edge sets the up state and a feedback edge sets the down state. When both states are due to be set, both are cleared. The width of the remaining active output is therefore the phase error, measured in system clock cycles. When the two frequencies differ, the leading state stays set across further edges of the same input. The output then saturates in one direction, which shows which frequency is higher.

A loop that locks at zero phase error sits inside the detector's dead-band and wanders. To avoid this, the block follows every phase-error pulse with a fixed-length offset pulse on one chosen line. The loop then settles with a small static phase error, just outside the dead-band. The length and polarity of the offset pulse are static configuration pins. A length of zero turns the offset off.

Top module: `pfd_offset_top`

## Requirements
- R1: While `rst` is high at a clock edge, and after reset is released with both inputs low, `up` and `dn` read 0.
- R2: A rising edge on `ref_in` that is held for at least three clocks sets `up` on the third rising clock edge after the input change. A rising edge on `fb_in` sets `dn` in the same way.
- R3: When the lagging input's edge is detected, the state that was set is cleared. The active output stays high for exactly as many clocks as separate the two edges.
- R4: If both edges are detected in the same clock, neither output is asserted and no offset pulse follows. `up` and `dn` are never high in the same cycle.
- R5: When a phase-error pulse ends, an offset pulse of `ofs_len` clocks starts in the very next cycle. It is driven on `up` when `ofs_pol` is 0 and on `dn` when `ofs_pol` is 1.
- R6: With `ofs_len` equal to 0, no offset pulse is produced and only the phase-error pulse appears.
- R7: Repeated edges on one input, with no edge on the other, keep that input's output high without a break. This is saturation.
- R8: An input edge detected during an offset pulse ends the offset pulse at once, and that edge starts a new error pulse.
- R9: The synchronous reset clears both state flops and the offset counter. An offset pulse that was cut by reset does not resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that oversamples both inputs |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Divided feedback clock, asynchronous |
| ofs_len | input | LEN_W | Offset pulse length in clocks; 0 turns the offset off |
| ofs_pol | input | 1 | Offset line select: 0 selects `up`, 1 selects `dn` |
| up | output | 1 | Charge-pump speed-up request |
| dn | output | 1 | Charge-pump slow-down request |

## Verification
The assertions assume that each input level is held for at least three system clocks, so that the edge detector sees every transition exactly once. They also assume that `ofs_len` and `ofs_pol` change only while the detector is idle, with no error pulse and no offset pulse active. The stimulus keeps every input pulse high for three clocks and writes the configuration only at the start of a scenario, after the previous scenario's pulses have ended. Reset is asserted only while the inputs are low.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned NUM_IN = 2;
  localparam int unsigned IDX_REF = 0;
  localparam int unsigned IDX_FB  = 1;

  typedef enum logic {
    OFS_ON_UP = 1'b0,
    OFS_ON_DN = 1'b1
  } ofs_pol_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      seen  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      seen  <= chain[LAST];
    end
  end

  assign rise = chain[LAST] & ~seen;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic ref_st,
  output logic fb_st,
  output logic err_done
);
  logic ref_nx, fb_nx, meet;

  always_comb begin
    ref_nx   = ref_st | ref_rise;
    fb_nx    = fb_st | fb_rise;
    meet     = ref_nx & fb_nx;
    err_done = meet & (ref_st | fb_st);
  end

  // The clear path is real logic, so the flops that only ever load a
  // constant 1 cannot be reduced to wires.
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_st <= 1'b0;
      fb_st  <= 1'b0;
    end else if (meet) begin
      ref_st <= 1'b0;
      fb_st  <= 1'b0;
    end else begin
      ref_st <= ref_nx;
      fb_st  <= fb_nx;
    end
  end
endmodule

// File: rtl/pfd_offset.sv
module pfd_offset
  import pfd_pkg::*;
#(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             abort,
  input  logic [LEN_W-1:0] len,
  input  ofs_pol_e         pol,
  output logic             ofs_on,
  output logic             ofs_up,
  output logic             ofs_dn
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                 remain <= '0;
    else if (load)           remain <= len;
    else if (abort)          remain <= '0;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign ofs_on = (remain != '0);
  assign ofs_up = ofs_on & (pol == OFS_ON_UP);
  assign ofs_dn = ofs_on & (pol == OFS_ON_DN);
endmodule

// File: rtl/pfd_offset_top.sv
module pfd_offset_top
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEN_W       = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [LEN_W-1:0] ofs_len,
  input  logic             ofs_pol,
  output logic             up,
  output logic             dn
);
  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] rise_vec;
  logic ref_rise, fb_rise;
  logic ref_st, fb_st, err_done;
  logic ofs_on, ofs_up, ofs_dn;

  assign raw_in[IDX_REF] = ref_in;
  assign raw_in[IDX_FB]  = fb_in;

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[gi]),
      .rise (rise_vec[gi])
    );
  end

  assign ref_rise = rise_vec[IDX_REF];
  assign fb_rise  = rise_vec[IDX_FB];

  pfd_core i_core (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .ref_st   (ref_st),
    .fb_st    (fb_st),
    .err_done (err_done)
  );

  pfd_offset #(.LEN_W(LEN_W)) i_offset (
    .clk    (clk),
    .rst    (rst),
    .load   (err_done),
    .abort  (ref_rise | fb_rise),
    .len    (ofs_len),
    .pol    (ofs_pol_e'(ofs_pol)),
    .ofs_on (ofs_on),
    .ofs_up (ofs_up),
    .ofs_dn (ofs_dn)
  );

  assign up = ref_st | ofs_up;
  assign dn = fb_st  | ofs_dn;
endmodule

// File: rtl/pfd_offset_chk.sv
module pfd_offset_chk #(
  parameter int unsigned LEN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             up,
  input logic             dn,
  input logic             ref_rise,
  input logic             fb_rise,
  input logic             ref_st,
  input logic             fb_st,
  input logic             ofs_on,
  input logic [LEN_W-1:0] ofs_len
);
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!up && !dn && !ofs_on));

  a_r2_ref_sets: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && !fb_rise && !fb_st) |=> ref_st);

  a_r3_lag_clears: assert property (@(posedge clk) disable iff (rst)
    (ref_st && fb_rise) |=> (!ref_st && !fb_st));

  a_r4_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && fb_rise && !ref_st && !fb_st) |=> (!ref_st && !fb_st && !ofs_on));

  a_r4_never_both: assert property (@(posedge clk) disable iff (rst)
    !(up && dn));

  a_r5_offset_idle: assert property (@(posedge clk) disable iff (rst)
    ofs_on |-> (!ref_st && !fb_st));

  a_r6_zero_len: assert property (@(posedge clk) disable iff (rst)
    (ofs_len == '0) |=> !ofs_on);

  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (ref_st && !fb_rise) |=> ref_st);

  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    (ofs_on && (ref_rise || fb_rise)) |=> !ofs_on);
endmodule

bind pfd_offset_top pfd_offset_chk #(.LEN_W(LEN_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .up       (up),
  .dn       (dn),
  .ref_rise (ref_rise),
  .fb_rise  (fb_rise),
  .ref_st   (ref_st),
  .fb_st    (fb_st),
  .ofs_on   (ofs_on),
  .ofs_len  (ofs_len)
);

// File: tb/test_pfd_offset_top.sv
module test_pfd_offset_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic [LEN_W-1:0] ofs_len = '0;
  logic ofs_pol = 1'b0;
  logic up, dn;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_offset_top #(.SYNC_STAGES(2), .LEN_W(LEN_W)) i_pfd_offset_top (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .ofs_len(ofs_len), .ofs_pol(ofs_pol), .up(up), .dn(dn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit in_hi(input int k, input int t0);
    return (t0 >= 0) && (k >= t0) && (k < t0 + 3);
  endfunction

  // Drives input pulses (3 clocks each) at given cycles, samples outputs
  // mid-cycle and checks high counts, run counts and up->dn handovers.
  task automatic run_case(input string req, input int r0, input int r1,
                          input int f0, input int f1, input int rk,
                          input int len, input bit pol, input int ncyc,
                          input int e_up, input int e_dn, input int e_ur,
                          input int e_dr, input int e_hand);
    int n_up = 0, n_dn = 0, n_ur = 0, n_dr = 0, n_hand = 0;
    bit p_up = 0, p_dn = 0;
    ofs_len = len[LEN_W-1:0];
    ofs_pol = pol;
    for (int k = 0; k < ncyc; k++) begin
      @(posedge clk);
      #1;
      ref_in = in_hi(k, r0) || in_hi(k, r1);
      fb_in  = in_hi(k, f0) || in_hi(k, f1);
      rst    = (k == rk);
      @(negedge clk);
      if (up) n_up++;
      if (dn) n_dn++;
      if (up && !p_up) n_ur++;
      if (dn && !p_dn) n_dr++;
      if (dn && p_up) n_hand++;
      p_up = up;
      p_dn = dn;
    end
    rst = 1'b0;
    check(req, "up cycles", n_up, e_up);
    check(req, "dn cycles", n_dn, e_dn);
    check(req, "up runs", n_ur, e_ur);
    check(req, "dn runs", n_dr, e_dr);
    check(req, "up-to-dn handovers", n_hand, e_hand);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "up in reset", int'(up), 0);
    check("R1", "dn in reset", int'(dn), 0);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "up after reset", int'(up), 0);
    check("R1", "dn after reset", int'(dn), 0);
  endtask

  // R2 R3 R6: reference leads by 5, no offset
  task automatic t_ref_lead();
    run_case("R3", 0, -1, 5, -1, -1, 0, 0, 20, 5, 0, 1, 0, 0);
  endtask

  // R2 R3: feedback leads by 7
  task automatic t_fb_lead();
    run_case("R2", 7, -1, 0, -1, -1, 0, 0, 25, 0, 7, 0, 1, 0);
  endtask

  // R5: offset of 3 on up merges with error pulse of 4
  task automatic t_ofs_up();
    run_case("R5", 0, -1, 4, -1, -1, 3, 0, 25, 7, 0, 1, 0, 0);
  endtask

  // R5: offset of 3 on dn right after up error of 4
  task automatic t_ofs_dn();
    run_case("R5", 0, -1, 4, -1, -1, 3, 1, 25, 4, 3, 1, 1, 1);
  endtask

  // R4: simultaneous edges, no output and no offset
  task automatic t_same();
    run_case("R4", 0, -1, 0, -1, -1, 3, 1, 20, 0, 0, 0, 0, 0);
  endtask

  // R7: two reference edges then one feedback edge
  task automatic t_saturate();
    run_case("R7", 0, 6, 10, -1, -1, 0, 0, 25, 10, 0, 1, 0, 0);
  endtask

  // R8: new reference edge cuts a 20-cycle dn offset after 5 cycles
  task automatic t_abort();
    run_case("R8", 0, 7, 2, 10, -1, 20, 1, 45, 5, 25, 2, 2, 2);
  endtask

  // R9: reset during up offset; offset must not resume
  task automatic t_reset_mid();
    run_case("R9", 0, -1, 3, -1, 10, 30, 0, 45, 8, 0, 1, 0, 0);
  endtask

  // R5 R6 boundaries: maximum length on dn, length 1 on up
  task automatic t_lengths();
    run_case("R5", 0, -1, 2, -1, -1, 63, 1, 80, 2, 63, 1, 1, 1);
    run_case("R6", 3, -1, 0, -1, -1, 1, 0, 20, 1, 3, 1, 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_ref_lead();
    t_fb_lead();
    t_ofs_up();
    t_ofs_dn();
    t_same();
    t_saturate();
    t_abort();
    t_reset_mid();
    t_lengths();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule